// File: doc/BRIEF.md
# Group Address Hash Filter

This block decides, while a frame's header is still arriving, whether its 48-bit destination address belongs to a multicast group that software has enabled. Each address byte is folded into an Ethernet CRC-32. Eight bits taken from the finished checksum select one bin out of 256. The bins are held in eight 32-bit registers, and software sets or clears bins through a plain write port and a matching read port, so a change to one bin is a read-modify-write of one register.

The address enters as a byte stream with valid/ready. The beat that carries `s_start` is the first byte, which is the most significant byte of the address. The next five accepted beats complete the address. `s_ready` is high whenever the block is out of reset. The block never applies back-pressure: a cycle with `s_valid` low simply pauses the byte count. One cycle after the sixth byte is accepted, `res_valid` pulses for one cycle and `res_accept` gives the verdict. An address whose group bit is clear always reports "not matched".

Top module: `mhf_filter`

## Requirements
- R1: After reset, all eight table registers read zero, `res_valid` and `res_accept` are low, and `s_ready` is high.
- R2: `res_valid` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the sixth address byte. `res_accept` is never high outside that cycle.
- R3: The checksum starts from all ones at the start beat. Bytes are taken in arrival order, each byte least-significant bit first, using the CRC-32 generator 0x04C11DB7 with no final inversion. The bin index is the top 8 bits of the resulting 32-bit value, read in MSB-first form.
- R4: Index bits [7:5] select the register. Index bits [4:0] select a bit counted down from bit 31, so bin 0 is bit 31 of register 0 and bin 255 is bit 0 of register 7.
- R5: If bit 0 of the first address byte (the group bit) is 0, `res_accept` is 0 whatever the table holds.
- R6: A write with `wr_en` replaces register `wr_idx` with `wr_data` at the clock edge and leaves the other seven unchanged. `rd_data` always shows register `rd_idx`.
- R7: The lookup uses the table as it stood before the clock edge that accepts the sixth byte. A write in that same cycle, or in the result cycle, does not change the verdict.
- R8: A beat with `s_start` always restarts the address at byte one, even in the middle of an address. The abandoned address produces no result.
- R9: Beats without `s_start` that arrive after a completed address, or before any start, are ignored and produce no result.
- R10: Cycles with `s_valid` low between address bytes pause the count without changing the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Address byte valid |
| s_ready | output | 1 | Byte accepted when high together with s_valid |
| s_start | input | 1 | Marks the first address byte |
| s_data | input | 8 | Address byte |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_accept | output | 1 | Address hashes to a set bin and is a group address |
| wr_en | input | 1 | Table register write enable |
| wr_idx | input | 3 | Register written |
| wr_data | input | 32 | New register contents |
| rd_idx | input | 3 | Register shown on rd_data |
| rd_data | output | 32 | Contents of register rd_idx |

## Verification
The checks assume that the address is at least two bytes long, so two verdict strobes can never fall in adjacent cycles. They also assume that `s_start` only carries meaning when a byte is actually accepted, and that inputs are defined once reset is released. The stimulus drives every input half a cycle away from the sampling edge. It raises `s_start` only on beats with `s_valid` high, and it always sends complete six-byte addresses, except when it deliberately abandons one with a new start. Write-port activity is lined up with the sixth byte and with the result cycle so that the ordering rule is tested at both edges.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int unsigned CRC_W = 32;
  // Reflected form of the Ethernet generator, for a right-shifting register.
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_PRESET    = '1;

  // Fold one byte into the reflected checksum, least-significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [7:0]       d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int k = 0; k < 8; k++) begin
      fb = c[0] ^ d[k];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/mhf_crc.sv
module mhf_crc
  import mhf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             start,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc_next
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;

  assign crc_base = start ? CRC_PRESET : crc_q;
  assign crc_next = crc_fold_byte(crc_base, data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_PRESET;
    else if (take) crc_q <= crc_next;
  end

endmodule

// File: rtl/mhf_ctrl.sv
module mhf_ctrl #(
  parameter  int ADDR_BYTES = 6,
  localparam int CNT_W      = $clog2(ADDR_BYTES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic start,
  input  logic grp_in,
  output logic take,
  output logic last,
  output logic grp_cur
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             grp_q;

  assign take    = beat & (start | busy_q);
  assign last    = take & (start ? (ADDR_BYTES == 1) : (cnt_q == CNT_W'(ADDR_BYTES - 1)));
  assign grp_cur = start ? grp_in : grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      grp_q  <= 1'b0;
    end else if (take) begin
      busy_q <= ~last;
      cnt_q  <= start ? CNT_W'(1) : cnt_q + CNT_W'(1);
      if (start) grp_q <= grp_in;
    end
  end

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter  int REG_W = 32,
  parameter  int SEL_W = 3,
  localparam int NREGS = 1 << SEL_W,
  localparam int TBL_W = NREGS * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  output logic [TBL_W-1:0] regs_flat
);

  for (genvar r = 0; r < NREGS; r++) begin : g_row
    logic [REG_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  row_q <= '0;
      else if (wr_en && (wr_idx == SEL_W'(r)))     row_q <= wr_data;
    end

    assign regs_flat[r*REG_W +: REG_W] = row_q;
  end

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
#(
  parameter  int ADDR_BYTES = 6,
  parameter  int IDX_W      = 8,
  parameter  int REG_W      = 32,
  localparam int BIT_W      = $clog2(REG_W),
  localparam int SEL_W      = IDX_W - BIT_W,
  localparam int NREGS      = 1 << SEL_W,
  localparam int TBL_W      = NREGS * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_start,
  input  logic [7:0]       s_data,
  output logic             res_valid,
  output logic             res_accept,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data
);

  logic             ready_q;
  logic             beat;
  logic             take;
  logic             last;
  logic             grp_cur;
  logic [CRC_W-1:0] crc_next;
  logic [TBL_W-1:0] regs_flat;
  logic [IDX_W-1:0] bin_idx;
  logic [SEL_W-1:0] bin_sel;
  logic [BIT_W-1:0] bin_pos;
  logic             bin_hit;
  logic             res_valid_q;
  logic             res_accept_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign s_ready = ready_q;
  assign beat    = s_valid & ready_q;

  mhf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat),
    .start   (s_start),
    .grp_in  (s_data[0]),
    .take    (take),
    .last    (last),
    .grp_cur (grp_cur)
  );

  mhf_crc u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .start    (s_start),
    .data     (s_data),
    .crc_next (crc_next)
  );

  mhf_table #(.REG_W(REG_W), .SEL_W(SEL_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .regs_flat (regs_flat)
  );

  // Reflected register: the low bits, reversed, are the top bits of the MSB-first checksum.
  for (genvar k = 0; k < IDX_W; k++) begin : g_idx
    assign bin_idx[k] = crc_next[IDX_W-1-k];
  end

  assign bin_sel = bin_idx[IDX_W-1 -: SEL_W];
  assign bin_pos = bin_idx[BIT_W-1:0];
  // Bit numbering counts down from the register MSB: position p lives at REG_W-1-p.
  assign bin_hit = regs_flat[{bin_sel, ~bin_pos}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q  <= 1'b0;
      res_accept_q <= 1'b0;
    end else begin
      res_valid_q  <= last;
      res_accept_q <= last & grp_cur & bin_hit;
    end
  end

  assign res_valid  = res_valid_q;
  assign res_accept = res_accept_q;
  assign rd_data    = regs_flat[{rd_idx, {BIT_W{1'b0}}} +: REG_W];

endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
  parameter int ADDR_BYTES = 6,
  parameter int REG_W      = 32,
  parameter int SEL_W      = 3,
  parameter int TBL_W      = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_start,
  input logic             s_grp,
  input logic             res_valid,
  input logic             res_accept,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_idx,
  input logic [REG_W-1:0] wr_data,
  input logic [TBL_W-1:0] regs_flat
);

  localparam int BIT_W = $clog2(REG_W);

  // Reference byte counter kept apart from the design's own sequencing.
  int   seen_c;
  logic fire_c;
  logic grp_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_c <= 0;
      fire_c <= 1'b0;
      grp_c  <= 1'b0;
    end else begin
      fire_c <= 1'b0;
      if (s_valid && s_ready) begin
        if (s_start) begin
          grp_c  <= s_grp;
          seen_c <= 1;
          fire_c <= (ADDR_BYTES == 1);
        end else if (seen_c > 0 && seen_c < ADDR_BYTES) begin
          seen_c <= seen_c + 1;
          fire_c <= (seen_c == ADDR_BYTES - 1);
        end
      end
    end
  end

  assert_result_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == fire_c);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_accept_in_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> res_valid);

  assert_group_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> grp_c);

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_flat[{$past(wr_idx), {BIT_W{1'b0}}} +: REG_W] == $past(wr_data)));

  assert_table_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

endmodule

bind mhf_filter mhf_filter_chk #(
  .ADDR_BYTES (ADDR_BYTES),
  .REG_W      (REG_W),
  .SEL_W      (SEL_W),
  .TBL_W      (TBL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .s_start    (s_start),
  .s_grp      (s_data[0]),
  .res_valid  (res_valid),
  .res_accept (res_accept),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .regs_flat  (regs_flat)
);

// File: tb/mhf_filter_test.sv
module mhf_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        s_start = 1'b0;
  logic [7:0]  s_data = '0;
  logic        res_valid;
  logic        res_accept;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  logic [31:0] mtbl [8];

  always #10 clk = ~clk;

  mhf_filter uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_start(s_start), .s_data(s_data), .res_valid(res_valid),
    .res_accept(res_accept), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always @(negedge clk) if (rst_n && res_valid) pulses++;

  // {program bin first, address}
  localparam logic [48:0] VEC [8] = '{
    {1'b1, 48'h01005E000001}, {1'b0, 48'h01005E7F0002},
    {1'b1, 48'h333300000001}, {1'b0, 48'h0180C2000000},
    {1'b1, 48'h020000000001}, {1'b1, 48'hFFFFFFFFFFFF},
    {1'b0, 48'h01005E000001}, {1'b0, 48'h090000000000}
  };

  function automatic logic [7:0] bin_of(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  d;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      d = a[47-8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ d[k];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:24];
  endfunction

  function automatic logic model_hit(input logic [47:0] a);
    logic [7:0] i;
    i = bin_of(a);
    return a[40] & mtbl[i[7:5]][31 - i[4:0]];
  endfunction

  function automatic logic [47:0] find_addr(input logic [7:0] want, input logic grp);
    logic [47:0] a;
    for (int n = 0; n < 100000; n++) begin
      a = 48'h01005E000000 + 48'(n);
      a[40] = grp;
      if (bin_of(a) == want) return a;
    end
    return 48'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    mtbl[idx] = val;
  endtask

  task automatic set_bin(input logic [7:0] i);
    rd_idx = i[7:5];
    #1;
    check("R6 read before modify", rd_data, mtbl[i[7:5]]);
    wr_reg(i[7:5], rd_data | (32'h8000_0000 >> i[4:0]));
  endtask

  // wmode 0: no write; 1: clear register widx with the sixth byte; 2: clear it in the result cycle
  task automatic send_addr(input logic [47:0] a, input int gap, input int wmode,
                           input logic [2:0] widx, output logic v, output logic acc);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_start = (i == 0); s_data = a[47-8*i -: 8];
      if (i == 5 && wmode == 1) begin wr_en = 1'b1; wr_idx = widx; wr_data = '0; end
      if (i < 5) for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        s_valid = 1'b0; s_start = 1'b0;
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_start = 1'b0; wr_en = 1'b0;
    if (wmode == 2) begin wr_en = 1'b1; wr_idx = widx; wr_data = '0; end
    #1;
    v = res_valid; acc = res_accept;
    if (wmode != 0) mtbl[widx] = '0;
    if (wmode == 2) begin @(negedge clk); wr_en = 1'b0; end
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic v, acc;
    logic [47:0] a0, a255, au;
    int p0;
    for (int r = 0; r < 8; r++) mtbl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      rd_idx = 3'(r);
      #1;
      check("R1 register clear", rd_data, 32'h0);
    end
    check("R1 no strobe", {30'h0, res_valid, res_accept}, 32'h0);
    check("R1 ready", {31'h0, s_ready}, 32'h1);

    // Vector walk: R3 hashing against the bench model, R5 unicast rejection
    foreach (VEC[n]) begin
      if (VEC[n][48]) set_bin(bin_of(VEC[n][47:0]));
      send_addr(VEC[n][47:0], 0, 0, 3'd0, v, acc);
      check("R2 strobe after sixth byte", {31'h0, v}, 32'h1);
      check("R3 verdict", {31'h0, acc}, {31'h0, model_hit(VEC[n][47:0])});
    end

    // R4: corner bins 0 and 255
    for (int r = 0; r < 8; r++) wr_reg(3'(r), 32'h0);
    a0   = find_addr(8'd0, 1'b1);
    a255 = find_addr(8'd255, 1'b1);
    wr_reg(3'd0, 32'h4000_0000);
    send_addr(a0, 0, 0, 3'd0, v, acc);
    check("R4 bin 1 set does not pass bin 0", {31'h0, acc}, 32'h0);
    wr_reg(3'd0, 32'h8000_0000);
    send_addr(a0, 0, 0, 3'd0, v, acc);
    check("R4 bin 0 is reg0 bit31", {31'h0, acc}, 32'h1);
    send_addr(a255, 0, 0, 3'd0, v, acc);
    check("R4 bin 255 clear", {31'h0, acc}, 32'h0);
    wr_reg(3'd7, 32'h0000_0001);
    send_addr(a255, 0, 0, 3'd0, v, acc);
    check("R4 bin 255 is reg7 bit0", {31'h0, acc}, 32'h1);
    rd_idx = 3'd3;
    #1;
    check("R6 other registers untouched", rd_data, 32'h0);

    // R5: all bins set, group bit clear
    for (int r = 0; r < 8; r++) wr_reg(3'(r), 32'hFFFF_FFFF);
    au = 48'h0A1B2C3D4E5F;
    send_addr(au, 0, 0, 3'd0, v, acc);
    check("R5 unicast rejected", {30'h0, v, acc}, 32'h2);
    send_addr(au | 48'h010000000000, 0, 0, 3'd0, v, acc);
    check("R5 group passes full table", {31'h0, acc}, 32'h1);

    // R7: writes in the sixth-byte cycle and in the result cycle
    send_addr(a0, 0, 1, 3'd0, v, acc);
    check("R7 write with sixth byte not seen", {31'h0, acc}, 32'h1);
    send_addr(a0, 0, 0, 3'd0, v, acc);
    check("R7 cleared register now rejects", {31'h0, acc}, 32'h0);
    send_addr(a255, 0, 2, 3'd7, v, acc);
    check("R7 result stable over write", {30'h0, v, acc}, 32'h3);
    rd_idx = 3'd7;
    #1;
    check("R6 result-cycle write landed", rd_data, 32'h0);

    // R10: gaps between bytes
    wr_reg(3'd0, 32'h8000_0000);
    p0 = pulses;
    send_addr(a0, 3, 0, 3'd0, v, acc);
    check("R10 gapped address verdict", {30'h0, v, acc}, 32'h3);
    check("R10 one strobe", 32'(pulses - p0), 32'h1);

    // R8: abandoned address then restart
    p0 = pulses;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_start = (i == 0); s_data = 8'h01;
    end
    send_addr(a0, 0, 0, 3'd0, v, acc);
    check("R8 restart verdict", {30'h0, v, acc}, 32'h3);
    check("R8 only one strobe", 32'(pulses - p0), 32'h1);

    // R9: trailing beats without start
    p0 = pulses;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_start = 1'b0; s_data = 8'(i);
    end
    @(negedge clk);
    s_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 stray beats ignored", 32'(pulses - p0), 32'h0);

    finish_up();
  end

endmodule